// File: doc/BRIEF.md
# GPIO Port Controller

This block manages a port of general-purpose pins behind a plain word-wide register bus. Each pin is either under software control, where it acts as an input or an output, or it is handed to one of four peripheral functions that supply their own drive value and output enable. Each pin also has pad control bits: pull-up, pull-down, open-drain (only a low level is driven), an inverted Schmitt select and an interrupt mask. A synchronized copy of the pad level can be read back.

Most configuration attributes use paired write-one-to-set and write-one-to-clear addresses, so software changes one pin without a read-modify-write. A keyed write-protect mode can lock the pin-ownership and pad configuration. Writes to output data stay open while the lock is on. A blocked write raises a violation flag and records the offset that caused it.

Top module: `gpio_port`

## Requirements
- R1: After reset, every pin is software-controlled (ownership status all ones) with its output disabled. Pull-ups are all enabled. Pull-down, open-drain, filter, interrupt-mask, output-data and both select words are zero, and protection is off.
- R2: Attribute k (0 ownership, 1 output enable, 2 filter, 3 open-drain, 4 pull-up, 5 pull-down, 6 interrupt mask, 7 output data) has its set address at word 3k, its clear address at 3k+1 and its status at 3k+2. A 1 in bit n sets or clears pin n. A 0 bit leaves that pin unchanged.
- R3: Output data changes only through its set address (21) and clear address (22). The resulting values read back at word 23 and appear on padOut for software-controlled pins.
- R4: For a software-controlled pin, padOe follows its output-enable status. For a peripheral-owned pin, padOut and padOe come from the selected peripheral.
- R5: The peripheral index of pin n is {sel2[n], sel1[n]}: A=0 (0,0), B=1 (sel1 set), C=2 (sel2 set), D=3 (both set). sel1 is the plain read-write word 25 and sel2 is the plain read-write word 26.
- R6: When open-drain is set on a pin, padOe is asserted only while the pin's drive value is 0.
- R7: Word 27 is a read-write Schmitt word. A 0 bit enables the Schmitt input, so padSchmittEn is the inverse of that word and is all ones after reset.
- R8: Word 24 returns the pad level through a two-stage synchronizer. A change on padIn becomes visible on the second rising edge after it.
- R9: While clkEn is low, the synchronizer holds, and word 24 keeps the level sampled before the clock was disabled.
- R10: While locked, writes to the set and clear addresses of attributes 0 to 5 and to both select words are ignored. Writes to output data, the interrupt mask and the Schmitt word still take effect.
- R11: Word 28 holds the lock bit in bit 0. A write changes the lock bit only when bits [31:8] equal 0x50494F. Writing the key with bit 0 set locks; writing it with bit 0 clear unlocks.
- R12: A blocked write sets bit 0 of word 29 and stores the word address in bits [23:8]. A read of word 29 returns the status and clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Word address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRd | input | 1 | Read strobe (side effect on word 29) |
| busRdData | output | 32 | Read data, combinational from busAddr |
| clkEn | input | 1 | Port clock enable for input sampling |
| padIn | input | 32 | Pad levels |
| perDout | input | 4x32 | Drive values from peripherals A..D |
| perOe | input | 4x32 | Output enables from peripherals A..D |
| padOut | output | 32 | Pad drive values |
| padOe | output | 32 | Pad output enables |
| padPullUp | output | 32 | Pull-up enables |
| padPullDn | output | 32 | Pull-down enables |
| padSchmittEn | output | 32 | Schmitt input enables |

## Verification
The hardest case to reach is a port state where the lock, a recorded violation and peripheral-owned pins all exist together. The checks must show that a blocked write to a select word leaves a peripheral pin's pad drive untouched, while an allowed write to output data still lands. The bench builds this state in steps. It first hands four pins to four different peripherals, each giving a distinct one-hot pattern. It then locks the port, including one attempt with a wrong key, and fires blocked and allowed writes at it. It watches the pad ports and the cleared-on-read status word after each write. Synchronizer latency and the hold while clkEn is low are checked edge by edge by reading word 24 without a clock edge in between.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 5;
  localparam int NATTR  = 8;

  // attribute indices: set at 3k, clear at 3k+1, status at 3k+2
  localparam int AT_OWN = 0;
  localparam int AT_OE  = 1;
  localparam int AT_FLT = 2;
  localparam int AT_MD  = 3;
  localparam int AT_PU  = 4;
  localparam int AT_PD  = 5;
  localparam int AT_IM  = 6;
  localparam int AT_DAT = 7;

  localparam logic [NATTR-1:0] ATTR_RST_ONES = 8'b0001_0001; // ownership and pull-up
  localparam logic [NATTR-1:0] ATTR_PROT     = 8'b0011_1111; // locked attributes

  localparam logic [REG_AW-1:0] A_PIN_LVL = 5'd24;
  localparam logic [REG_AW-1:0] A_SEL1    = 5'd25;
  localparam logic [REG_AW-1:0] A_SEL2    = 5'd26;
  localparam logic [REG_AW-1:0] A_SCH     = 5'd27;
  localparam logic [REG_AW-1:0] A_WP_MODE = 5'd28;
  localparam logic [REG_AW-1:0] A_WP_STAT = 5'd29;

  typedef struct packed {
    logic [NATTR-1:0] setV;
    logic [NATTR-1:0] clrV;
    logic             sel1Wr;
    logic             sel2Wr;
    logic             schWr;
  } cfgStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int                KEY_W  = 24,
  parameter logic [KEY_W-1:0]  WP_KEY = 24'h50494F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [KEY_W-1:0]  modeKey,
  input  logic              modeLock,
  output cfgStrobe_t        stb,
  output logic [31:0]       ctrlRdData,
  output logic              ctrlRdHit
);
  logic        wpEn;
  logic        wpFlag;
  logic [15:0] wpOffs;
  logic        protHit;
  logic        keyOk;

  assign keyOk = (modeKey == WP_KEY);

  always_comb begin
    stb     = '0;
    protHit = 1'b0;
    for (int k = 0; k < NATTR; k++) begin
      if (busWr && busAddr == REG_AW'(3*k)) begin
        if (wpEn && ATTR_PROT[k]) protHit = 1'b1;
        else stb.setV[k] = 1'b1;
      end
      if (busWr && busAddr == REG_AW'(3*k+1)) begin
        if (wpEn && ATTR_PROT[k]) protHit = 1'b1;
        else stb.clrV[k] = 1'b1;
      end
    end
    if (busWr && busAddr == A_SEL1) begin
      if (wpEn) protHit = 1'b1;
      else stb.sel1Wr = 1'b1;
    end
    if (busWr && busAddr == A_SEL2) begin
      if (wpEn) protHit = 1'b1;
      else stb.sel2Wr = 1'b1;
    end
    if (busWr && busAddr == A_SCH) stb.schWr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpEn   <= 1'b0;
      wpFlag <= 1'b0;
      wpOffs <= '0;
    end else begin
      if (busWr && busAddr == A_WP_MODE && keyOk) wpEn <= modeLock;
      if (protHit) begin
        wpFlag <= 1'b1;
        wpOffs <= 16'(busAddr);
      end else if (busRd && busAddr == A_WP_STAT) begin
        wpFlag <= 1'b0;
        wpOffs <= '0;
      end
    end
  end

  always_comb begin
    ctrlRdHit  = 1'b0;
    ctrlRdData = '0;
    if (busAddr == A_WP_MODE) begin
      ctrlRdHit  = 1'b1;
      ctrlRdData = {31'b0, wpEn};
    end else if (busAddr == A_WP_STAT) begin
      ctrlRdHit  = 1'b1;
      ctrlRdData = {8'b0, wpOffs, 7'b0, wpFlag};
    end
  end

  // R2: at most one configuration strobe per bus cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setV, stb.clrV, stb.sel1Wr, stb.sel2Wr, stb.schWr}));

  // R12: a write into a locked register raises the violation flag
  a_r12_flag_on_block: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && wpEn && (busAddr == 5'd3 || busAddr == A_SEL1)) |=> wpFlag);

  // R11: a mode write with a wrong key leaves the lock untouched
  a_r11_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_WP_MODE && !keyOk) |=> $stable(wpEn));
endmodule

// File: rtl/gpio_port_dpath.sv
module gpio_port_dpath
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            stb,
  input  logic [REG_AW-1:0]     busAddr,
  input  logic [NPINS-1:0]      busWrData,
  input  logic                  clkEn,
  input  logic [NPINS-1:0]      padIn,
  input  logic [3:0][NPINS-1:0] perDout,
  input  logic [3:0][NPINS-1:0] perOe,
  output logic [NPINS-1:0]      padOut,
  output logic [NPINS-1:0]      padOe,
  output logic [NPINS-1:0]      padPullUp,
  output logic [NPINS-1:0]      padPullDn,
  output logic [NPINS-1:0]      padSchmittEn,
  output logic [NPINS-1:0]      dpRdData
);
  logic [NPINS-1:0] attrQ [NATTR];
  logic [NPINS-1:0] sel1Q, sel2Q, schQ;
  logic [NPINS-1:0] syncQ1, syncQ2;

  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    logic [NPINS-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= ATTR_RST_ONES[k] ? '1 : '0;
      else       q <= (q | (stb.setV[k] ? busWrData : '0)) & ~(stb.clrV[k] ? busWrData : '0);
    end
    assign attrQ[k] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel1Q <= '0;
      sel2Q <= '0;
      schQ  <= '0;
    end else begin
      if (stb.sel1Wr) sel1Q <= busWrData;
      if (stb.sel2Wr) sel2Q <= busWrData;
      if (stb.schWr)  schQ  <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= '0;
      syncQ2 <= '0;
    end else if (clkEn) begin
      syncQ1 <= padIn;
      syncQ2 <= syncQ1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] fsel;
    logic       driveVal;
    logic       oeRaw;
    assign fsel     = {sel2Q[i], sel1Q[i]};
    assign driveVal = attrQ[AT_OWN][i] ? attrQ[AT_DAT][i] : perDout[fsel][i];
    assign oeRaw    = attrQ[AT_OWN][i] ? attrQ[AT_OE][i]  : perOe[fsel][i];
    assign padOut[i] = driveVal;
    assign padOe[i]  = oeRaw & ~(attrQ[AT_MD][i] & driveVal);
  end

  assign padPullUp    = attrQ[AT_PU];
  assign padPullDn    = attrQ[AT_PD];
  assign padSchmittEn = ~schQ;

  always_comb begin
    dpRdData = '0;
    for (int k = 0; k < NATTR; k++)
      if (busAddr == REG_AW'(3*k+2)) dpRdData = attrQ[k];
    if (busAddr == A_PIN_LVL) dpRdData = syncQ2;
    if (busAddr == A_SEL1)    dpRdData = sel1Q;
    if (busAddr == A_SEL2)    dpRdData = sel2Q;
    if (busAddr == A_SCH)     dpRdData = schQ;
  end

  // R9: with the port clock off the sensed level is frozen
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(syncQ2));

  // R6: an open-drain pin never actively drives a high level
  a_r6_no_drive_high: assert property (@(posedge clk) disable iff (!rstN)
    (attrQ[AT_MD] & padOe & padOut) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_AW-1:0]     busAddr,
  input  logic                  busWr,
  input  logic [31:0]           busWrData,
  input  logic                  busRd,
  output logic [31:0]           busRdData,
  input  logic                  clkEn,
  input  logic [NPINS-1:0]      padIn,
  input  logic [3:0][NPINS-1:0] perDout,
  input  logic [3:0][NPINS-1:0] perOe,
  output logic [NPINS-1:0]      padOut,
  output logic [NPINS-1:0]      padOe,
  output logic [NPINS-1:0]      padPullUp,
  output logic [NPINS-1:0]      padPullDn,
  output logic [NPINS-1:0]      padSchmittEn
);
  cfgStrobe_t       stb;
  logic [31:0]      ctrlRdData;
  logic             ctrlRdHit;
  logic [NPINS-1:0] dpRdData;

  gpio_port_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .modeKey    (busWrData[31:8]),
    .modeLock   (busWrData[0]),
    .stb        (stb),
    .ctrlRdData (ctrlRdData),
    .ctrlRdHit  (ctrlRdHit)
  );

  gpio_port_dpath #(.NPINS(NPINS)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .busAddr      (busAddr),
    .busWrData    (busWrData[NPINS-1:0]),
    .clkEn        (clkEn),
    .padIn        (padIn),
    .perDout      (perDout),
    .perOe        (perOe),
    .padOut       (padOut),
    .padOe        (padOe),
    .padPullUp    (padPullUp),
    .padPullDn    (padPullDn),
    .padSchmittEn (padSchmittEn),
    .dpRdData     (dpRdData)
  );

  assign busRdData = ctrlRdHit ? ctrlRdData : 32'(dpRdData);
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [4:0]       busAddr = '0;
  logic             busWr = 1'b0;
  logic [31:0]      busWrData = '0;
  logic             busRd = 1'b0;
  logic [31:0]      busRdData;
  logic             clkEn = 1'b1;
  logic [31:0]      padIn = '0;
  logic [3:0][31:0] perDout = '0;
  logic [3:0][31:0] perOe = '0;
  logic [31:0]      padOut, padOe, padPullUp, padPullDn, padSchmittEn;

  int nChecks = 0;
  int nErrors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  localparam logic [31:0] KEY = 32'h50494F00;

  always #2 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
    .busRd(busRd), .busRdData(busRdData), .clkEn(clkEn), .padIn(padIn),
    .perDout(perDout), .perOe(perOe), .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .padPullDn(padPullDn), .padSchmittEn(padSchmittEn)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [4:0] a, input bit withStrobe, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
    if (withStrobe) begin
      busRd = 1'b1;
      @(posedge clk); @(negedge clk);
      busRd = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd2, 0, v);  chk("R1 ownership", v, 32'hFFFFFFFF);
    rd(5'd5, 0, v);  chk("R1 oe status", v, 32'h0);
    rd(5'd14, 0, v); chk("R1 pull-up status", v, 32'hFFFFFFFF);
    rd(5'd17, 0, v); chk("R1 pull-down status", v, 32'h0);
    rd(5'd28, 0, v); chk("R1 lock off", v, 32'h0);
    chk("R1 padOe", padOe, 32'h0);
    chk("R7 schmitt default", padSchmittEn, 32'hFFFFFFFF);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(5'd3, 32'h000000F0);
    wr(5'd3, 32'h00000003);
    rd(5'd5, 0, v); chk("R2 set accumulates", v, 32'h000000F3);
    wr(5'd4, 32'h00000010);
    rd(5'd5, 0, v); chk("R2 clear one bit", v, 32'h000000E3);
    wr(5'd13, 32'h00000001);
    chk("R2 pull-up clear", padPullUp, 32'hFFFFFFFE);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(5'd21, 32'h000000A5);
    wr(5'd22, 32'h00000005);
    rd(5'd23, 0, v); chk("R3 data status", v, 32'h000000A0);
    chk("R3 padOut", {24'h0, padOut[7:0]}, 32'h000000A0);
    chk("R4 sw padOe", {24'h0, padOe[7:0]}, 32'h000000E3);
  endtask

  task automatic t_periph();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      perDout[k] = 32'h1 << (8 + k);
      perOe[k]   = (k == 1) ? 32'h0 : (32'h1 << (8 + k));
    end
    wr(5'd25, 32'h00000A00);
    wr(5'd26, 32'h00000C00);
    wr(5'd1, 32'h00000F00);
    rd(5'd2, 0, v); chk("R2 ownership cleared", v, 32'hFFFFF0FF);
    chk("R5 peripheral data mux", {28'h0, padOut[11:8]}, 32'hF);
    chk("R4 peripheral oe mux", {28'h0, padOe[11:8]}, 32'hD);
  endtask

  task automatic t_md();
    wr(5'd9, 32'h00000003);
    wr(5'd21, 32'h00000001);
    chk("R6 open-drain oe", {30'h0, padOe[1:0]}, 32'h2);
    chk("R6 open-drain out", {30'h0, padOut[1:0]}, 32'h1);
  endtask

  task automatic t_schmitt();
    logic [31:0] v;
    wr(5'd27, 32'h00000001);
    rd(5'd27, 0, v); chk("R7 schmitt readback", v, 32'h1);
    chk("R7 schmitt inverted", padSchmittEn, 32'hFFFFFFFE);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    padIn = 32'h12345678;
    @(posedge clk); @(negedge clk);
    rd(5'd24, 0, v); chk("R8 one edge not yet", v, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(5'd24, 0, v); chk("R8 second edge", v, 32'h12345678);
  endtask

  task automatic t_clken();
    logic [31:0] v;
    clkEn = 1'b0;
    padIn = 32'hCAFEF00D;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rd(5'd24, 0, v); chk("R9 held while off", v, 32'h12345678);
    clkEn = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    rd(5'd24, 0, v); chk("R9 resumes", v, 32'hCAFEF00D);
  endtask

  task automatic t_protect();
    logic [31:0] v;
    wr(5'd28, KEY | 32'h1);
    rd(5'd28, 0, v); chk("R11 locked", v, 32'h1);
    wr(5'd3, 32'hFF000000);
    rd(5'd5, 0, v); chk("R10 oe set blocked", v, 32'h000000E3);
    rd(5'd29, 1, v); chk("R12 violation status", v, 32'h00000301);
    rd(5'd29, 1, v); chk("R12 cleared by read", v, 32'h0);
    wr(5'd25, 32'h0);
    chk("R10 select blocked at pad", {31'h0, padOut[9]}, 32'h1);
    wr(5'd21, 32'h80000000);
    rd(5'd23, 0, v); chk("R10 data set allowed", v, 32'h800000A1);
    wr(5'd18, 32'h00000004);
    rd(5'd20, 0, v); chk("R10 mask allowed", v, 32'h4);
    wr(5'd28, 32'h12345600);
    rd(5'd28, 0, v); chk("R11 wrong key ignored", v, 32'h1);
    wr(5'd28, KEY);
    rd(5'd28, 0, v); chk("R11 unlocked", v, 32'h0);
    wr(5'd3, 32'h00000100);
    rd(5'd5, 0, v); chk("R11 write after unlock", v, 32'h000001E3);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_data();
    t_periph();
    t_md();
    t_schmitt();
    t_sync();
    t_clken();
    t_protect();
    summary();
  end
endmodule